// File: doc/BRIEF.md
# Planar Raster-Operation Write Unit

This block rewrites one byte address in every enabled bit-plane of a planar video memory. A processor access to a proxy window raises a trigger with a byte address. For each enabled plane the unit reads the stored byte and builds a new byte with the selected logic operation. It merges that byte into the old one under a write mask, and can apply a second merge under a pixel-status byte. It then writes the result back before moving to the next plane.

Software first sets up the unit through a small register-write port. That port holds the command, the per-plane colour bits, the write mask, the plane-skip bits, the pixel-status byte and one pattern byte per plane. After that, every proxy access is one trigger. The unit handles the planes one after another over a shared plane-memory port, with one read cycle and one write cycle per plane. It raises `busy` while it works and gives a one-cycle `done` pulse at the end.

Top module: `plane_rop_unit`

## Requirements
- R1: After reset every register is zero, so the unit is disabled: `busy`, `done`, `mem_rd` and `mem_wr` stay low, and a trigger causes no memory access.
- R2: When command bit 7 is 0, a trigger is ignored. There is no memory access, no `busy` and no `done`.
- R3: An accepted trigger makes `busy` high from the next cycle. Each processed plane then takes a read cycle (`mem_rd`) followed by a write cycle (`mem_wr`) on the same plane and address. Planes are handled in ascending index order. A single-cycle `done`, with `busy` still high, follows the last write, and `busy` is low in the cycle after that.
- R4: Plane i is processed only if i < min(`plane_cnt`, 4) and bit i of the plane-skip register (select 3) is 0.
- R5: Command bits 2:0 select the operation, and bit i of the colour register (select 1) is plane i's colour. The codes are: 0 writes 0xFF if the colour is 1, else 0x00. 1 writes 0x00. 2 ORs the old byte with 0xFF or 0x00. 3 ANDs it with 0xFF or 0x00. 4 XORs it with 0xFF or 0x00. 5 inverts it. In codes 2 to 4, 0xFF is used when the colour is 1.
- R6: Code 6 uses pattern register 8+i as the new byte for plane i.
- R7: Before any status merge, the write byte is (old & mask) | (new & ~mask). The mask is register 2.
- R8: When command bit 6 is 1, the masked byte is merged again with the old byte under the status register (select 4). If command bit 5 is 1, a status bit of 1 keeps the old pixel and a status bit of 0 takes the masked pixel. If bit 5 is 0, the roles are swapped.
- R9: With `mode400` high the 15-bit trigger address is used unchanged. With it low, address bit 14 is forced to 0.
- R10: With code 7, or when no plane qualifies, an accepted trigger makes no memory access. It gives only `done` and `busy` in the next cycle.
- R11: A trigger that arrives while `busy` is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 4 | Register select: 0 command, 1 colour, 2 mask, 3 plane skip, 4 status, 8..11 pattern |
| reg_wdata | input | 8 | Register write data |
| trig | input | 1 | Proxy access trigger |
| trig_addr | input | 15 | Byte address of the access |
| mode400 | input | 1 | Selects the 15-bit address space |
| plane_cnt | input | 3 | Number of planes present |
| mem_rd | output | 1 | Plane memory read; data is returned on `mem_rdata` one cycle later |
| mem_wr | output | 1 | Plane memory write |
| mem_plane | output | 2 | Plane index of the access |
| mem_addr | output | 15 | Byte address of the access |
| mem_wdata | output | 8 | Write data |
| mem_rdata | input | 8 | Read data, registered by the memory |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle end-of-operation pulse |

## Verification
The unit has two kinds of internal state: the pending-plane set and the latched address. If the pending set is corrupted, the fault shows up in the cycle right after the trigger, as a wrong plane index on `mem_rd`, an extra or missing read/write pair, or `done` in the wrong cycle. If the operation datapath or the mask and status merge is wrong, `mem_wdata` is wrong in the write cycle of the affected plane. That is two cycles after the trigger for the first plane. The bench compares every port against a cycle-accurate reference on every clock, so each of these faults is caught in the cycle where it first appears.

// File: rtl/plane_rop_unit.sv
module plane_rop_unit #(
  parameter  int DW   = 8,
  parameter  int AW   = 15,
  parameter  int NPL  = 4,
  parameter  int PCW  = 3,
  parameter  int SELW = 4,
  localparam int PLW  = (NPL > 1) ? $clog2(NPL) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            reg_we,
  input  logic [SELW-1:0] reg_sel,
  input  logic [DW-1:0]   reg_wdata,
  input  logic            trig,
  input  logic [AW-1:0]   trig_addr,
  input  logic            mode400,
  input  logic [PCW-1:0]  plane_cnt,
  output logic            mem_rd,
  output logic            mem_wr,
  output logic [PLW-1:0]  mem_plane,
  output logic [AW-1:0]   mem_addr,
  output logic [DW-1:0]   mem_wdata,
  input  logic [DW-1:0]   mem_rdata,
  output logic            busy,
  output logic            done
);

  localparam int SEL_CMD  = 0;
  localparam int SEL_COL  = 1;
  localparam int SEL_MASK = 2;
  localparam int SEL_SKIP = 3;
  localparam int SEL_STAT = 4;
  localparam int SEL_TILE = 8;

  localparam logic [2:0] OP_PSET  = 3'd0;
  localparam logic [2:0] OP_BLANK = 3'd1;
  localparam logic [2:0] OP_OR    = 3'd2;
  localparam logic [2:0] OP_AND   = 3'd3;
  localparam logic [2:0] OP_XOR   = 3'd4;
  localparam logic [2:0] OP_NOT   = 3'd5;
  localparam logic [2:0] OP_TILE  = 3'd6;
  localparam logic [2:0] OP_NONE  = 3'd7;

  typedef enum logic [1:0] {S_IDLE, S_RD, S_WR, S_FIN} state_t;

  state_t            st_q;
  logic [DW-1:0]     cmd_q, col_q, msk_q, skip_q, stat_q;
  logic [DW-1:0]     tile_q [NPL];
  logic [NPL-1:0]    pend_q;
  logic [PLW-1:0]    pl_q;
  logic [AW-1:0]     addr_q;
  logic              a400_q;

  logic [NPL-1:0]    cand, rest;
  logic [PCW-1:0]    lim;
  logic [2:0]        op;
  logic              colour, accept;
  logic [DW-1:0]     newb, masked;

  function automatic logic [PLW-1:0] first_set(input logic [NPL-1:0] v);
    first_set = '0;
    for (int i = NPL - 1; i >= 0; i--)
      if (v[i]) first_set = PLW'(i);
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd_q  <= '0;
      col_q  <= '0;
      msk_q  <= '0;
      skip_q <= '0;
      stat_q <= '0;
    end else if (reg_we) begin
      case (int'(reg_sel))
        SEL_CMD:  cmd_q  <= reg_wdata;
        SEL_COL:  col_q  <= reg_wdata;
        SEL_MASK: msk_q  <= reg_wdata;
        SEL_SKIP: skip_q <= reg_wdata;
        SEL_STAT: stat_q <= reg_wdata;
        default: ;
      endcase
    end
  end

  for (genvar g = 0; g < NPL; g++) begin : g_tile
    always_ff @(posedge clk) begin
      if (!rst_n)
        tile_q[g] <= '0;
      else if (reg_we && int'(reg_sel) == SEL_TILE + g)
        tile_q[g] <= reg_wdata;
    end
  end

  assign lim = (int'(plane_cnt) > NPL) ? PCW'(NPL) : plane_cnt;

  always_comb begin
    for (int i = 0; i < NPL; i++)
      cand[i] = (i < int'(lim)) && !skip_q[i];
  end

  assign op     = cmd_q[2:0];
  assign accept = (st_q == S_IDLE) && trig && cmd_q[7];
  assign rest   = pend_q & ~(NPL'(1) << pl_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= S_IDLE;
      pend_q <= '0;
      pl_q   <= '0;
      addr_q <= '0;
      a400_q <= 1'b0;
    end else begin
      case (st_q)
        S_IDLE: if (accept) begin
          addr_q <= trig_addr;
          a400_q <= mode400;
          pend_q <= cand;
          pl_q   <= first_set(cand);
          st_q   <= (op == OP_NONE || cand == '0) ? S_FIN : S_RD;
        end
        S_RD: st_q <= S_WR;
        S_WR: begin
          pend_q <= rest;
          pl_q   <= first_set(rest);
          st_q   <= (rest == '0) ? S_FIN : S_RD;
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end

  assign colour = col_q[pl_q];

  always_comb begin
    case (op)
      OP_PSET:  newb = {DW{colour}};
      OP_BLANK: newb = '0;
      OP_OR:    newb = mem_rdata | {DW{colour}};
      OP_AND:   newb = mem_rdata & {DW{colour}};
      OP_XOR:   newb = mem_rdata ^ {DW{colour}};
      OP_NOT:   newb = ~mem_rdata;
      OP_TILE:  newb = tile_q[pl_q];
      default:  newb = mem_rdata;
    endcase
  end

  assign masked = (mem_rdata & msk_q) | (newb & ~msk_q);

  always_comb begin
    if (!cmd_q[6])
      mem_wdata = masked;
    else if (cmd_q[5])
      mem_wdata = (mem_rdata & stat_q) | (masked & ~stat_q);
    else
      mem_wdata = (masked & stat_q) | (mem_rdata & ~stat_q);
  end

  assign mem_rd    = (st_q == S_RD);
  assign mem_wr    = (st_q == S_WR);
  assign mem_plane = pl_q;
  assign mem_addr  = a400_q ? addr_q : {1'b0, addr_q[AW-2:0]};
  assign busy      = (st_q != S_IDLE);
  assign done      = (st_q == S_FIN);

endmodule

// File: rtl/plane_rop_chk.sv
module plane_rop_chk #(
  parameter int AW  = 15,
  parameter int PLW = 2,
  parameter int PCW = 3,
  parameter int DW  = 8
) (
  input logic           clk,
  input logic           rst_n,
  input logic           trig,
  input logic           busy,
  input logic           done,
  input logic           mem_rd,
  input logic           mem_wr,
  input logic [PLW-1:0] mem_plane,
  input logic [AW-1:0]  mem_addr,
  input logic [PCW-1:0] plane_cnt,
  input logic [DW-1:0]  cmd,
  input logic [DW-1:0]  skip,
  input logic           a400
);

  AST_RD_THEN_WR: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd |=> mem_wr && $stable(mem_plane) && $stable(mem_addr)); // R3

  AST_WR_AFTER_RD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr |-> $past(mem_rd)); // R3

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done && !busy); // R3

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mem_rd && !mem_wr); // R3

  AST_DISABLED_TRIG: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && trig && !cmd[7]) |=> !busy); // R2

  AST_SKIPPED_PLANE: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd |-> !skip[mem_plane]); // R4

  AST_PLANE_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd |-> (int'(mem_plane) < int'(plane_cnt))); // R4

  AST_NARROW_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    ((mem_rd || mem_wr) && !a400) |-> !mem_addr[AW-1]); // R9

endmodule

bind plane_rop_unit plane_rop_chk #(.AW(AW), .PLW(PLW), .PCW(PCW), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .trig(trig), .busy(busy), .done(done),
  .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_plane(mem_plane), .mem_addr(mem_addr),
  .plane_cnt(plane_cnt), .cmd(cmd_q), .skip(skip_q), .a400(a400_q)
);

// File: tb/plane_rop_unit_tb.sv
module plane_rop_unit_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [3:0]  reg_sel = '0;
  logic [7:0]  reg_wdata = '0;
  logic        trig = 1'b0;
  logic [14:0] trig_addr = '0;
  logic        mode400 = 1'b1;
  logic [2:0]  plane_cnt = 3'd4;
  logic        mem_rd, mem_wr, busy, done;
  logic [1:0]  mem_plane;
  logic [14:0] mem_addr;
  logic [7:0]  mem_wdata;
  logic [7:0]  mem_rdata = '0;

  always #5 clk = ~clk;

  plane_rop_unit u_dut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
    .trig(trig), .trig_addr(trig_addr), .mode400(mode400), .plane_cnt(plane_cnt),
    .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_plane(mem_plane), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .busy(busy), .done(done)
  );

  typedef struct {
    bit    b, d, r, w;
    int    pl, adr, wd;
    string tag;
  } exp_t;

  exp_t   expq[$];
  int     vram[int];
  int     refm[int];
  int     checks = 0, fails = 0;
  string  idle_tag = "R1";
  string  cur_tag = "R5";
  bit     finished = 0;
  int     m_cmd = 0, m_col = 0, m_msk = 0, m_skip = 0, m_stat = 0;
  int     m_tile[4] = '{0, 0, 0, 0};

  function automatic int rdm(ref int m[int], input int k);
    return m.exists(k) ? m[k] : 0;
  endfunction

  always @(posedge clk) begin
    if (mem_rd) mem_rdata <= 8'(rdm(vram, int'(mem_plane) * 65536 + int'(mem_addr)));
    if (mem_wr) vram[int'(mem_plane) * 65536 + int'(mem_addr)] = int'(mem_wdata);
  end

  task automatic fail_line(string tag, string what, int act, int exp);
    fails++;
    $display("FAIL %s %s actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
  endtask

  always @(posedge clk) begin
    #3;
    if (rst_n && !finished) begin
      exp_t e;
      bit bad = 0;
      if (expq.size() != 0) e = expq.pop_front();
      else begin
        e.b = 0; e.d = 0; e.r = 0; e.w = 0; e.pl = 0; e.adr = 0; e.wd = 0; e.tag = idle_tag;
      end
      checks++;
      if ({busy, done, mem_rd, mem_wr} != {e.b, e.d, e.r, e.w}) begin
        fail_line(e.tag, "busy/done/rd/wr", int'({busy, done, mem_rd, mem_wr}), int'({e.b, e.d, e.r, e.w}));
        bad = 1;
      end
      if (!bad && (e.r || e.w) && (int'(mem_plane) != e.pl || int'(mem_addr) != e.adr)) begin
        fail_line(e.tag, "plane/addr", int'(mem_plane) * 65536 + int'(mem_addr), e.pl * 65536 + e.adr);
        bad = 1;
      end
      if (!bad && e.w && int'(mem_wdata) != e.wd)
        fail_line(e.tag, "wdata", int'(mem_wdata), e.wd);
    end
  end

  function automatic int ref_byte(int pl, int old);
    bit c = m_col[pl] == 1'b1;
    int nb, mb, res;
    case (m_cmd & 7)
      0: nb = c ? 255 : 0;
      1: nb = 0;
      2: nb = c ? 255 : old;
      3: nb = c ? old : 0;
      4: nb = c ? (old ^ 255) : old;
      5: nb = old ^ 255;
      6: nb = m_tile[pl];
      default: nb = old;
    endcase
    mb = 0;
    for (int k = 0; k < 8; k++)
      if (m_msk[k]) mb |= old & (1 << k);
      else          mb |= nb & (1 << k);
    res = mb;
    if (m_cmd[6]) begin
      res = 0;
      for (int k = 0; k < 8; k++) begin
        bit keep_old = m_stat[k] ? m_cmd[5] : !m_cmd[5];
        res |= (keep_old ? old : mb) & (1 << k);
      end
    end
    return res;
  endfunction

  task automatic predict(int a);
    int adr, lim, n;
    exp_t e;
    if (!m_cmd[7]) return;
    adr = mode400 ? (a & 32767) : (a & 16383);
    lim = (int'(plane_cnt) > 4) ? 4 : int'(plane_cnt);
    n = 0;
    if ((m_cmd & 7) != 7) begin
      for (int p = 0; p < lim; p++) begin
        if (m_skip[p]) continue;
        e.b = 1; e.d = 0; e.r = 1; e.w = 0; e.pl = p; e.adr = adr; e.wd = 0; e.tag = "R3";
        expq.push_back(e);
        e.r = 0; e.w = 1;
        e.wd = ref_byte(p, rdm(refm, p * 65536 + adr));
        e.tag = cur_tag;
        refm[p * 65536 + adr] = e.wd;
        expq.push_back(e);
        n++;
      end
    end
    e.b = 1; e.d = 1; e.r = 0; e.w = 0; e.pl = 0; e.adr = 0; e.wd = 0;
    e.tag = (n == 0) ? "R10" : "R3";
    expq.push_back(e);
  endtask

  task automatic setr(int sel, int val);
    @(negedge clk);
    reg_we = 1; reg_sel = 4'(sel); reg_wdata = 8'(val);
    case (sel)
      0: m_cmd = val;
      1: m_col = val;
      2: m_msk = val;
      3: m_skip = val;
      4: m_stat = val;
      default: if (sel >= 8 && sel < 12) m_tile[sel - 8] = val;
    endcase
    @(negedge clk);
    reg_we = 0;
  endtask

  task automatic poke(int p, int a, int v);
    vram[p * 65536 + a] = v;
    refm[p * 65536 + a] = v;
  endtask

  task automatic drain();
    while (expq.size() != 0) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  task automatic fire(int a, string tag);
    cur_tag = tag;
    @(negedge clk);
    trig = 1; trig_addr = 15'(a);
    predict(a);
    @(negedge clk);
    trig = 0;
    drain();
  endtask

  task automatic summary();
    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    #2_000_000;
    checks++;
    fails++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    for (int p = 0; p < 4; p++) begin
      poke(p, 16'h0123, 8'h5A + p * 17);
      poke(p, 16'h3ABC, 8'hC3 ^ (p * 9));
      poke(p, 16'h7ABC, 8'h3C + p);
    end
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);

    // R1: idle after reset; trigger with cleared command does nothing
    idle_tag = "R1";
    fire(16'h0123, "R1");

    // R2: enable bit clear, nonzero operation code
    idle_tag = "R2";
    setr(0, 8'h02);
    fire(16'h0123, "R2");
    idle_tag = "R3";

    // R5 and R7: every colour operation with a partial mask
    setr(1, 8'h05);
    setr(2, 8'h0F);
    for (int op = 0; op < 6; op++) begin
      setr(0, 8'h80 | op);
      fire(16'h0123, "R5");
    end
    setr(2, 8'h00);
    setr(0, 8'h84);
    fire(16'h0123, "R7");

    // R6: pattern bytes per plane
    setr(8, 8'hA1); setr(9, 8'hB2); setr(10, 8'hC3); setr(11, 8'hD4);
    setr(2, 8'h81);
    setr(0, 8'h86);
    fire(16'h0123, "R6");

    // R4: plane skip and plane-count limit
    setr(3, 8'h0A);
    plane_cnt = 3'd7;
    setr(0, 8'h85);
    fire(16'h0123, "R4");
    setr(3, 8'h00);
    plane_cnt = 3'd2;
    fire(16'h0123, "R4");
    plane_cnt = 3'd4;

    // R8: status merge, both polarities
    setr(4, 8'hF0);
    setr(2, 8'h00);
    setr(0, 8'hE5);
    fire(16'h0123, "R8");
    setr(0, 8'hC5);
    fire(16'h0123, "R8");

    // R9: address width by mode
    setr(0, 8'h85);
    mode400 = 1'b0;
    fire(16'h7ABC, "R9");
    mode400 = 1'b1;
    fire(16'h7ABC, "R9");

    // R10: compare-only code and all planes skipped
    setr(0, 8'h87);
    fire(16'h0123, "R10");
    setr(0, 8'h85);
    setr(3, 8'h0F);
    fire(16'h0123, "R10");
    setr(3, 8'h00);

    // R11: trigger during busy ignored
    cur_tag = "R11";
    @(negedge clk);
    trig = 1; trig_addr = 15'h0123;
    predict(16'h0123);
    @(negedge clk);
    trig_addr = 15'h3ABC;
    @(negedge clk);
    trig = 0;
    drain();
    fire(16'h3ABC, "R11");

    repeat (4) @(negedge clk);
    summary();
  end

endmodule